// File: doc/BRIEF.md
# Nibble-Serial CRC-16 Engine

This block computes a 16-bit check value over a run of 32-bit words. The words are treated as big-endian, and the check value protects the header of a table or a map on a serial bus. A run begins with a one-cycle `start` pulse, which carries the number of words to cover. The words then arrive one at a time over a valid/ready handshake. Each word is broken into eight 4-bit nibbles, the most significant nibble first, and one nibble is folded into the running value on each clock.

When the last nibble of the last word has been folded, the engine pulses `done` for one cycle. It then holds the 16-bit result and a ready-made header word until the next run begins. The header word puts the word count in the upper half and the check value in the lower half. A new `start` that arrives while a run is in progress abandons that run.

Top module: `crc16n_top`

## Requirements
- R1: After reset, `crc_out` is 0, `done` is 0 and `in_ready` is 0.
- R2: The clock edge that samples `start` clears the running value to 0 and loads `word_count`. If the count is nonzero, `in_ready` is high in the next cycle.
- R3: Each word is folded most significant nibble first: bits 31:28, then 27:24, and so on down to bits 3:0.
- R4: For each nibble n, s = (crc[15:12] XOR n) and crc becomes ((crc << 4) XOR (s << 12) XOR (s << 5) XOR s), kept to 16 bits. For a single word 0x00000001 the result is 0x1021.
- R5: One nibble is folded per clock. After a word is accepted, `in_ready` stays low for exactly 8 cycles and then returns high if more words remain.
- R6: `done` is high for exactly one cycle. It follows the edge that folds the final nibble of the final word, and `crc_out` holds the final value in that cycle.
- R7: After `done`, `crc_out` and `header_word` stay unchanged until the next `start`.
- R8: A `start` during a run abandons it. No `done` is produced for the abandoned run, and the running value is 0 in the cycle after that `start`.
- R9: `header_word` is {word count of the run (16 bits), crc (16 bits)}.
- R10: A `start` with a count of 0 gives a `done` pulse in the very next cycle, with a result of 0.
- R11: `in_valid` has no effect while `in_ready` is low. This holds while a word is being folded and while the engine is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | One-cycle pulse that begins a new run |
| word_count | input | LEN_W | Number of words in the run, sampled with `start` |
| in_valid | input | 1 | Input word is valid |
| in_word | input | WORD_W | Input word, big-endian nibble order |
| in_ready | output | 1 | Engine can take a word |
| done | output | 1 | One-cycle pulse when the run finishes |
| crc_out | output | 16 | Running and final check value |
| header_word | output | LEN_W+16 | Count and check value packed into one word |

## Verification
The bench uses the default parameters: 32-bit words, eight nibbles per word and a 16-bit count field. These values produce the 8-cycle busy window per word and the 32-bit header word with the count in its upper half. Runs of zero to six words can then be reached quickly, including runs that are abandoned mid-fold and runs whose input valid is held through the busy window. A single-word case, whose result is worked out by hand, anchors the recurrence independently of the bench's own model.

// File: rtl/crc16n_pkg.sv
package crc16n_pkg;

    localparam int CRC_W = 16;
    localparam int NIB_W = 4;

    typedef enum logic [1:0] {
        RUN_IDLE,
        RUN_WAIT,
        RUN_FOLD
    } run_state_e;

    // One 4-bit step of the shift/XOR recurrence.
    function automatic logic [CRC_W-1:0] fold_nibble(
        input logic [CRC_W-1:0] crc,
        input logic [NIB_W-1:0] nib
    );
        logic [NIB_W-1:0] s;
        logic [CRC_W-1:0] s_w;
        s   = crc[CRC_W-1 -: NIB_W] ^ nib;
        s_w = {{(CRC_W-NIB_W){1'b0}}, s};
        return (crc << NIB_W) ^ (s_w << 12) ^ (s_w << 5) ^ s_w;
    endfunction

endpackage

// File: rtl/crc16n_nib_shift.sv
module crc16n_nib_shift
    import crc16n_pkg::*;
#(
    parameter int WORD_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic              shift,
    input  logic [WORD_W-1:0] word_in,
    output logic [NIB_W-1:0]  nib_out
);
    logic [WORD_W-1:0] hold_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            hold_q <= '0;
        end else if (load) begin
            hold_q <= word_in;
        end else if (shift) begin
            hold_q <= hold_q << NIB_W;
        end
    end

    assign nib_out = hold_q[WORD_W-1 -: NIB_W];
endmodule

// File: rtl/crc16n_fold.sv
module crc16n_fold
    import crc16n_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             clear,
    input  logic             fold_en,
    input  logic [NIB_W-1:0] nib,
    output logic [CRC_W-1:0] crc
);
    logic [CRC_W-1:0] crc_q;

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            crc_q <= '0;
        end else if (fold_en) begin
            crc_q <= fold_nibble(crc_q, nib);
        end
    end

    assign crc = crc_q;
endmodule

// File: rtl/crc16n_ctrl.sv
module crc16n_ctrl
    import crc16n_pkg::*;
#(
    parameter int WORD_W = 32,
    parameter int LEN_W  = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic [LEN_W-1:0] word_count,
    input  logic             in_valid,
    output logic             in_ready,
    output logic             load,
    output logic             fold_en,
    output logic             done,
    output logic [LEN_W-1:0] run_len
);
    localparam int NIBS  = WORD_W / NIB_W;
    localparam int IDX_W = (NIBS > 1) ? $clog2(NIBS) : 1;
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NIBS - 1);

    run_state_e       state_q;
    logic [LEN_W-1:0] remain_q;
    logic [LEN_W-1:0] len_q;
    logic [IDX_W-1:0] idx_q;
    logic             done_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q  <= RUN_IDLE;
            remain_q <= '0;
            len_q    <= '0;
            idx_q    <= '0;
            done_q   <= 1'b0;
        end else begin
            done_q <= 1'b0;
            if (start) begin
                len_q    <= word_count;
                remain_q <= word_count;
                idx_q    <= '0;
                if (word_count == '0) begin
                    state_q <= RUN_IDLE;
                    done_q  <= 1'b1;
                end else begin
                    state_q <= RUN_WAIT;
                end
            end else begin
                case (state_q)
                    RUN_WAIT: begin
                        if (in_valid) begin
                            state_q <= RUN_FOLD;
                            idx_q   <= '0;
                        end
                    end
                    RUN_FOLD: begin
                        idx_q <= idx_q + 1'b1;
                        if (idx_q == LAST_IDX) begin
                            remain_q <= remain_q - 1'b1;
                            if (remain_q == LEN_W'(1)) begin
                                state_q <= RUN_IDLE;
                                done_q  <= 1'b1;
                            end else begin
                                state_q <= RUN_WAIT;
                            end
                        end
                    end
                    default: state_q <= RUN_IDLE;
                endcase
            end
        end
    end

    assign in_ready = (state_q == RUN_WAIT);
    assign load     = in_ready && in_valid && !start;
    assign fold_en  = (state_q == RUN_FOLD) && !start;
    assign done     = done_q;
    assign run_len  = len_q;
endmodule

// File: rtl/crc16n_top.sv
module crc16n_top
    import crc16n_pkg::*;
#(
    parameter int WORD_W = 32,
    parameter int LEN_W  = 16
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   start,
    input  logic [LEN_W-1:0]       word_count,
    input  logic                   in_valid,
    input  logic [WORD_W-1:0]      in_word,
    output logic                   in_ready,
    output logic                   done,
    output logic [CRC_W-1:0]       crc_out,
    output logic [LEN_W+CRC_W-1:0] header_word
);
    logic             load;
    logic             fold_en;
    logic [NIB_W-1:0] cur_nib;
    logic [LEN_W-1:0] run_len;

    crc16n_ctrl #(.WORD_W(WORD_W), .LEN_W(LEN_W)) u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .start     (start),
        .word_count(word_count),
        .in_valid  (in_valid),
        .in_ready  (in_ready),
        .load      (load),
        .fold_en   (fold_en),
        .done      (done),
        .run_len   (run_len)
    );

    crc16n_nib_shift #(.WORD_W(WORD_W)) u_shift (
        .clk    (clk),
        .rst    (rst),
        .load   (load),
        .shift  (fold_en),
        .word_in(in_word),
        .nib_out(cur_nib)
    );

    crc16n_fold u_fold (
        .clk    (clk),
        .rst    (rst),
        .clear  (start),
        .fold_en(fold_en),
        .nib    (cur_nib),
        .crc    (crc_out)
    );

    assign header_word = {run_len, crc_out};
endmodule

// File: rtl/crc16n_chk.sv
module crc16n_chk #(
    parameter int LEN_W = 16
) (
    input logic                clk,
    input logic                rst,
    input logic                start,
    input logic [LEN_W-1:0]    word_count,
    input logic                in_valid,
    input logic                in_ready,
    input logic                done,
    input logic [15:0]         crc_out,
    input logic [LEN_W+15:0]   header_word
);
    logic settled_q;

    always_ff @(posedge clk) begin
        if (rst || start) settled_q <= 1'b0;
        else if (done)    settled_q <= 1'b1;
    end

    p_clear_on_start_r2: assert property (@(posedge clk) disable iff (rst)
        start |=> crc_out == 16'h0);

    p_len_field_r9: assert property (@(posedge clk) disable iff (rst)
        start |=> header_word[LEN_W+15:16] == $past(word_count));

    p_busy_after_accept_r5: assert property (@(posedge clk) disable iff (rst)
        (in_ready && in_valid && !start) |=> !in_ready);

    p_done_single_r6: assert property (@(posedge clk) disable iff (rst)
        (done && !start) |=> !done);

    p_done_not_ready_r6: assert property (@(posedge clk) disable iff (rst)
        done |-> !in_ready);

    p_hold_result_r7: assert property (@(posedge clk) disable iff (rst)
        (settled_q && !start) |=> ($stable(crc_out) && $stable(header_word)));
endmodule

bind crc16n_top crc16n_chk #(.LEN_W(LEN_W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .start      (start),
    .word_count (word_count),
    .in_valid   (in_valid),
    .in_ready   (in_ready),
    .done       (done),
    .crc_out    (crc_out),
    .header_word(header_word)
);

// File: tb/tb_crc16n_top.sv
module tb_crc16n_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic [15:0] word_count = '0;
    logic        in_valid = 1'b0;
    logic [31:0] in_word = '0;
    logic        in_ready;
    logic        done;
    logic [15:0] crc_out;
    logic [31:0] header_word;

    int errors = 0;
    int checks = 0;
    logic [31:0] exp_q[$];
    logic [31:0] seed = 32'h1234_5678;

    always #5 clk = ~clk;

    crc16n_top dut (
        .clk(clk), .rst(rst), .start(start), .word_count(word_count),
        .in_valid(in_valid), .in_word(in_word), .in_ready(in_ready),
        .done(done), .crc_out(crc_out), .header_word(header_word)
    );

    task automatic check(input bit ok, input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [15:0] model(input logic [31:0] ws[$]);
        logic [31:0] c = 0;
        logic [31:0] s;
        foreach (ws[i]) begin
            for (int sh = 28; sh >= 0; sh -= 4) begin
                s = ((c >> 12) ^ (ws[i] >> sh)) & 32'hf;
                c = ((c << 4) ^ (s << 12) ^ (s << 5) ^ s) & 32'hffff;
            end
        end
        return c[15:0];
    endfunction

    function automatic logic [31:0] next_rand();
        seed = seed * 32'd1664525 + 32'd1013904223;
        return seed;
    endfunction

    // Monitor: pops expected results on every done pulse (R6, R9)
    always @(negedge clk) begin
        if (!rst && done) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "R8 unexpected done", {16'h0, crc_out}, 32'h0);
            end else begin
                logic [31:0] e;
                e = exp_q.pop_front();
                check(crc_out == e[15:0], "R6 crc at done", {16'h0, crc_out}, {16'h0, e[15:0]});
                check(header_word == e, "R9 header word", header_word, e);
            end
        end
    end

    task automatic pulse_start(input logic [15:0] n);
        @(negedge clk);
        start = 1'b1;
        word_count = n;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic send_word(input logic [31:0] w);
        while (1) begin
            @(negedge clk);
            if (in_ready) break;
        end
        in_valid = 1'b1;
        in_word = w;
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic wait_empty();
        int guard = 0;
        while (exp_q.size() != 0 && guard < 200) begin
            @(negedge clk);
            guard++;
        end
        check(exp_q.size() == 0, "R6 done never seen", exp_q.size(), 0);
    endtask

    task automatic run(input logic [31:0] ws[$]);
        exp_q.push_back({16'(ws.size()), model(ws)});
        pulse_start(16'(ws.size()));
        foreach (ws[i]) send_word(ws[i]);
        wait_empty();
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks + 1);
        $finish;
    end

    initial begin
        logic [31:0] ws[$];
        logic [15:0] held;
        int lows;

        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1
        check(crc_out == 0, "R1 crc after reset", {16'h0, crc_out}, 0);
        check(done == 0, "R1 done after reset", {31'h0, done}, 0);
        check(in_ready == 0, "R1 ready after reset", {31'h0, in_ready}, 0);

        // R4 hand-worked value
        exp_q.push_back({16'd1, 16'h1021});
        pulse_start(1);
        send_word(32'h0000_0001);
        wait_empty();

        // R3 nibble order: top nibble first differs from bottom nibble
        ws = {32'h1000_0000};
        run(ws);
        check(model(ws) != 16'h1021, "R3 order distinguishes", {16'h0, model(ws)}, 32'h1021);

        // R2 clear and ready after start; R5 busy window
        exp_q.push_back({16'd2, model({32'hdead_beef, 32'h0123_4567})});
        pulse_start(2);
        check(crc_out == 0, "R2 crc cleared", {16'h0, crc_out}, 0);
        check(in_ready == 1, "R2 ready after start", {31'h0, in_ready}, 1);
        send_word(32'hdead_beef);
        lows = 0;
        while (!in_ready && lows < 20) begin
            lows++;
            @(negedge clk);
        end
        check(lows == 8, "R5 busy cycles", lows, 8);
        send_word(32'h0123_4567);
        wait_empty();

        // R7 hold after done, and R11 idle valid ignored
        held = crc_out;
        @(negedge clk);
        in_valid = 1'b1;
        in_word = 32'hffff_ffff;
        repeat (5) @(negedge clk);
        in_valid = 1'b0;
        check(crc_out == held, "R7 R11 result held", {16'h0, crc_out}, {16'h0, held});
        check(done == 0, "R7 no extra done", {31'h0, done}, 0);
        check(header_word == {16'd2, held}, "R7 header held", header_word, {16'd2, held});

        // R10 zero count
        exp_q.push_back({16'd0, 16'h0});
        pulse_start(0);
        wait_empty();

        // R8 abort mid-fold
        pulse_start(4);
        send_word(32'hcafe_f00d);
        exp_q.push_back({16'd2, model({32'h0bad_cafe, 32'h7777_0001})});
        pulse_start(2);
        check(crc_out == 0, "R8 crc cleared on abort", {16'h0, crc_out}, 0);
        check(in_ready == 1, "R8 ready after abort", {31'h0, in_ready}, 1);
        send_word(32'h0bad_cafe);
        send_word(32'h7777_0001);
        wait_empty();

        // R11 valid held high with junk during fold
        exp_q.push_back({16'd1, model({32'h89ab_cdef})});
        pulse_start(1);
        while (!in_ready) @(negedge clk);
        in_valid = 1'b1;
        in_word = 32'h89ab_cdef;
        @(negedge clk);
        in_word = 32'h5555_aaaa;
        repeat (12) @(negedge clk);
        in_valid = 1'b0;
        wait_empty();
        check(crc_out == model({32'h89ab_cdef}), "R11 junk ignored",
              {16'h0, crc_out}, {16'h0, model({32'h89ab_cdef})});

        // R4 R6 assorted runs
        for (int r = 0; r < 20; r++) begin
            int n;
            n = 1 + (next_rand() % 6);
            ws = {};
            for (int k = 0; k < n; k++) ws.push_back(next_rand());
            run(ws);
        end

        repeat (5) @(negedge clk);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule